// File: doc/BRIEF.md
# Shared Mailbox Bank with Aggregated Interrupts

This block holds a small bank of single-slot 32-bit mailboxes that processors use to pass messages to one another over a simple register bus. A producer posts a message by writing a word whose top bit is set, and that bit doubles as the mailbox's occupied flag. A consumer drains the mailbox by writing zero, which clears both the payload and the flag.

Each mailbox drives two level conditions, one for empty and one for full. Each condition is gated by its own enable bit inside the mailbox window. The gated conditions of all mailboxes are packed into one live status word. Several interrupt lines share that status word, and each line has its own enable mask. A line stays high for as long as any status bit selected by its mask is set. A read-only dimensioning word reports the configured counts of each resource type.

The 16-bit address is split in two. The upper four bits pick a page, and the lower twelve bits pick a register offset inside that page. Page 0 holds the common registers. Page 1+i is the window of mailbox i.

Top module: `shmbox_bank`

## Requirements
- R1: After reset, every mailbox word is 0, every enable bit (per mailbox and per line) is 0, the status word reads 0 and every interrupt line is low.
- R2: A write to offset 0x000 of mailbox page 1+i stores the whole 32-bit word. The word reads back unchanged, and the mailbox counts as full exactly when bit 31 of the stored word is 1.
- R3: Writing 0x0 to a mailbox word empties the mailbox, and a later read of that word returns 0.
- R4: The status word at common offset 0x304 has bit i = (mailbox i empty AND its empty-enable) and bit 8+i = (mailbox i full AND its full-enable). Bits 31:16, and the bits of mailboxes that are not implemented, read 0.
- R5: Interrupt line x is high exactly while (status AND enable mask x) is nonzero. It is a level that holds until the state or the mask changes, and it changes only after a bus write.
- R6: Enable mask x sits at common offset 0x100 + 4*x. It stores bits 15:0 of the written word and reads back with bits 31:16 at 0. The masks of different lines are independent.
- R7: Common offset 0x380 reads the mailbox count in [3:0], the semaphore count in [7:4], the arbitrated semaphore count in [11:8], the doorbell count in [15:12] and the interrupt line count in [19:16]. With default parameters the value is 0x00040008.
- R8: Writes to the status word and to the dimensioning word change no state: the status, the interrupt lines and the dimensioning value all stay the same.
- R9: Reads of offsets that are not implemented, of pages 9 to 15, and of mailbox pages above the configured count return 0.
- R10: A write with bit 31 set to a mailbox that is already full replaces the data, and the mailbox stays full.
- R11: Mailbox offset 0x004 is the full-enable bit and offset 0x008 is the empty-enable bit. Each stores bit 0 of the written word and reads back in bit 0, with all other bits 0.
- R12: A read request in one cycle gives bus_rvalid high and the data in the next cycle. bus_rvalid is low and bus_rdata is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address: page in [15:12], offset in [11:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | NUM_SHINT | Level interrupt lines, one per enable mask |

## Verification
The bank is driven with seeded random mixes of posts, drains, enable-bit writes, mask writes and read-backs across all mailboxes. Every interrupt line and every status read is compared against a model. This separates errors in the data path, in the bit placement of the empty and full halves of the status word, and in the routing of masks to lines. Directed cases cover the reset state, an overwrite of a full mailbox, and words with bit 31 clear but a nonzero payload. They also cover writes aimed at read-only registers and reads of unmapped pages and offsets. These cases show that ignored writes leave no trace and that holes read as zero.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;

    localparam int BUS_AW    = 16;
    localparam int BUS_DW    = 32;
    localparam int PAGE_W    = 4;
    localparam int OFS_W     = 12;
    localparam int MAX_MBOX  = 8;
    localparam int STAT_W    = 2 * MAX_MBOX;
    localparam int FULL_POS  = BUS_DW - 1;

    localparam logic [OFS_W-1:0] OFS_MB_DATA = 12'h000;
    localparam logic [OFS_W-1:0] OFS_MB_FIE  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_MB_EIE  = 12'h008;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h304;
    localparam logic [OFS_W-1:0] OFS_DIM     = 12'h380;
    localparam logic [3:0]       EN_PAGE_HI  = 4'h1;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_COMMON = 2'd1,
        TGT_MBOX   = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [2:0]       mb_idx;
        logic [OFS_W-1:0] ofs;
        logic             en_hit;
        logic [5:0]       en_idx;
    } dec_t;

    function automatic logic [BUS_DW-1:0] dim_word(input int n_mb, input int n_ss,
                                                   input int n_as, input int n_db,
                                                   input int n_si);
        logic [BUS_DW-1:0] w;
        w        = '0;
        w[3:0]   = 4'(n_mb);
        w[7:4]   = 4'(n_ss);
        w[11:8]  = 4'(n_as);
        w[15:12] = 4'(n_db);
        w[19:16] = 4'(n_si);
        return w;
    endfunction

endpackage

// File: rtl/shmbox_decode.sv
module shmbox_decode
    import shmbox_pkg::*;
#(
    parameter int NUM_MBOX  = 8,
    parameter int NUM_SHINT = 4
) (
    input  logic [BUS_AW-1:0] addr,
    output dec_t              dec
);
    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;

    assign page = addr[BUS_AW-1 -: PAGE_W];
    assign ofs  = addr[OFS_W-1:0];

    always_comb begin
        dec        = '0;
        dec.ofs    = ofs;
        dec.tgt    = TGT_NONE;
        dec.mb_idx = '0;
        if (page == '0) begin
            dec.tgt = TGT_COMMON;
        end else if (int'(page) <= NUM_MBOX) begin
            dec.tgt    = TGT_MBOX;
            dec.mb_idx = 3'(page - 1'b1);
        end
        dec.en_idx = ofs[7:2];
        dec.en_hit = (ofs[11:8] == EN_PAGE_HI) && (ofs[1:0] == 2'b00)
                     && (int'(ofs[7:2]) < NUM_SHINT);
    end
endmodule

// File: rtl/shmbox_slot.sv
module shmbox_slot
    import shmbox_pkg::*;
#(
    parameter bit HAS_IE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic              wr_fie,
    input  logic              wr_eie,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] data_q,
    output logic              fie_rd,
    output logic              eie_rd,
    output logic              empty_cond,
    output logic              full_cond
);
    logic full_gate;
    logic empty_gate;

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (wr_data) data_q <= wdata;
    end

    generate
        if (HAS_IE) begin : g_ie
            logic fie_q;
            logic eie_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    fie_q <= 1'b0;
                    eie_q <= 1'b0;
                end else begin
                    if (wr_fie) fie_q <= wdata[0];
                    if (wr_eie) eie_q <= wdata[0];
                end
            end
            assign full_gate  = fie_q;
            assign empty_gate = eie_q;
            assign fie_rd     = fie_q;
            assign eie_rd     = eie_q;
        end else begin : g_no_ie
            assign full_gate  = 1'b1;
            assign empty_gate = 1'b1;
            assign fie_rd     = 1'b0;
            assign eie_rd     = 1'b0;
        end
    endgenerate

    assign full_cond  = data_q[FULL_POS] & full_gate;
    assign empty_cond = ~data_q[FULL_POS] & empty_gate;
endmodule

// File: rtl/shmbox_irq_agg.sv
module shmbox_irq_agg
    import shmbox_pkg::*;
#(
    parameter int NUM_SHINT = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_SHINT-1:0]              en_wr,
    input  logic [STAT_W-1:0]                 wmask,
    input  logic [STAT_W-1:0]                 status,
    output logic [NUM_SHINT-1:0][STAT_W-1:0]  en_q,
    output logic [NUM_SHINT-1:0]              irq_out
);
    genvar x;
    generate
        for (x = 0; x < NUM_SHINT; x++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst)           en_q[x] <= '0;
                else if (en_wr[x]) en_q[x] <= wmask;
            end
            assign irq_out[x] = |(status & en_q[x]);
        end
    endgenerate
endmodule

// File: rtl/shmbox_bank.sv
module shmbox_bank
    import shmbox_pkg::*;
#(
    parameter int NUM_MBOX  = 8,
    parameter int NUM_SHINT = 4,
    parameter int NUM_SS    = 0,
    parameter int NUM_AS    = 0,
    parameter int NUM_DB    = 0,
    parameter bit HAS_IE    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [15:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic [NUM_SHINT-1:0] irq_out
);
    localparam logic [BUS_DW-1:0] DIM_VAL =
        dim_word(NUM_MBOX, NUM_SS, NUM_AS, NUM_DB, NUM_SHINT);

    dec_t                              dec;
    logic                              wr_go;
    logic                              rd_go;
    logic [NUM_MBOX-1:0]               wr_data;
    logic [NUM_MBOX-1:0]               wr_fie;
    logic [NUM_MBOX-1:0]               wr_eie;
    logic [NUM_MBOX-1:0][BUS_DW-1:0]   mb_data;
    logic [NUM_MBOX-1:0]               mb_fie;
    logic [NUM_MBOX-1:0]               mb_eie;
    logic [NUM_MBOX-1:0]               mb_empty;
    logic [NUM_MBOX-1:0]               mb_full;
    logic [STAT_W-1:0]                 status;
    logic [NUM_SHINT-1:0]              en_wr;
    logic [NUM_SHINT-1:0][STAT_W-1:0]  en_q;
    logic [BUS_DW-1:0]                 rd_next;

    assign wr_go = bus_sel & bus_we;
    assign rd_go = bus_sel & ~bus_we;

    shmbox_decode #(
        .NUM_MBOX  (NUM_MBOX),
        .NUM_SHINT (NUM_SHINT)
    ) u_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_MBOX; i++) begin : g_mb
            logic hit;
            assign hit        = wr_go && (dec.tgt == TGT_MBOX) && (int'(dec.mb_idx) == i);
            assign wr_data[i] = hit && (dec.ofs == OFS_MB_DATA);
            assign wr_fie[i]  = hit && (dec.ofs == OFS_MB_FIE);
            assign wr_eie[i]  = hit && (dec.ofs == OFS_MB_EIE);

            shmbox_slot #(.HAS_IE(HAS_IE)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .wr_data    (wr_data[i]),
                .wr_fie     (wr_fie[i]),
                .wr_eie     (wr_eie[i]),
                .wdata      (bus_wdata),
                .data_q     (mb_data[i]),
                .fie_rd     (mb_fie[i]),
                .eie_rd     (mb_eie[i]),
                .empty_cond (mb_empty[i]),
                .full_cond  (mb_full[i])
            );
        end
    endgenerate

    always_comb begin
        status = '0;
        for (int k = 0; k < NUM_MBOX; k++) begin
            status[k]            = mb_empty[k];
            status[MAX_MBOX + k] = mb_full[k];
        end
    end

    always_comb begin
        en_wr = '0;
        for (int x = 0; x < NUM_SHINT; x++)
            en_wr[x] = wr_go && (dec.tgt == TGT_COMMON) && dec.en_hit
                       && (int'(dec.en_idx) == x);
    end

    shmbox_irq_agg #(.NUM_SHINT(NUM_SHINT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (en_wr),
        .wmask   (bus_wdata[STAT_W-1:0]),
        .status  (status),
        .en_q    (en_q),
        .irq_out (irq_out)
    );

    always_comb begin
        rd_next = '0;
        case (dec.tgt)
            TGT_COMMON: begin
                if (dec.ofs == OFS_STATUS)
                    rd_next = BUS_DW'(status);
                else if (dec.ofs == OFS_DIM)
                    rd_next = DIM_VAL;
                else if (dec.en_hit)
                    for (int x = 0; x < NUM_SHINT; x++)
                        if (int'(dec.en_idx) == x) rd_next = BUS_DW'(en_q[x]);
            end
            TGT_MBOX: begin
                for (int k = 0; k < NUM_MBOX; k++) begin
                    if (int'(dec.mb_idx) == k) begin
                        if (dec.ofs == OFS_MB_DATA)     rd_next = mb_data[k];
                        else if (dec.ofs == OFS_MB_FIE) rd_next = BUS_DW'(mb_fie[k]);
                        else if (dec.ofs == OFS_MB_EIE) rd_next = BUS_DW'(mb_eie[k]);
                    end
                end
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_go;
            bus_rdata  <= rd_go ? rd_next : '0;
        end
    end
endmodule

// File: rtl/shmbox_bank_chk.sv
module shmbox_bank_chk #(
    parameter int NUM_SHINT = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [15:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 bus_rvalid,
    input logic [NUM_SHINT-1:0] irq_out
);
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we) |=> bus_rvalid); // R12

    AST_NO_IDLE_RVALID: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> !bus_rvalid); // R12

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == 32'h0)); // R12

    AST_IRQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_out) |-> $past(bus_sel && bus_we)); // R5

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (irq_out == '0)); // R1

    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && (bus_addr == 16'h0304)) |=> $stable(irq_out)); // R8

    AST_DIM_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && (bus_addr == 16'h0380)) |=> $stable(irq_out)); // R8
endmodule

bind shmbox_bank shmbox_bank_chk #(.NUM_SHINT(NUM_SHINT)) u_chk (.*);

// File: tb/shmbox_bank_tb.sv
module shmbox_bank_tb;
    localparam int NM = 8;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NI-1:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_data [NM];
    logic        m_fie  [NM];
    logic        m_eie  [NM];
    logic [15:0] m_en   [NI];

    always #10 clk = ~clk;

    shmbox_bank u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        for (int k = 0; k < NM; k++) begin
            s[k]     = m_eie[k] & ~m_data[k][31];
            s[8 + k] = m_fie[k] &  m_data[k][31];
        end
        return s;
    endfunction

    function automatic logic [NI-1:0] exp_irq();
        logic [NI-1:0] v;
        logic [15:0]   s = exp_status();
        for (int x = 0; x < NI; x++) v[x] = |(s & m_en[x]);
        return v;
    endfunction

    function automatic logic [15:0] mb_addr(input int k, input logic [11:0] ofs);
        return 16'((k + 1) << 12) | 16'(ofs);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
        check("R12 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic check_irq(input string req);
        check(req, 32'(irq_out), 32'(exp_irq()));
    endtask

    task automatic model_write(input logic [15:0] a, input logic [31:0] d);
        int pg = int'(a[15:12]);
        if (pg >= 1 && pg <= NM) begin
            if (a[11:0] == 12'h000) m_data[pg-1] = d;
            if (a[11:0] == 12'h004) m_fie[pg-1]  = d[0];
            if (a[11:0] == 12'h008) m_eie[pg-1]  = d[0];
        end else if (pg == 0) begin
            for (int x = 0; x < NI; x++)
                if (a[11:0] == 12'(12'h100 + 4 * x)) m_en[x] = d[15:0];
        end
    endtask

    task automatic do_write(input string req, input logic [15:0] a, input logic [31:0] d);
        model_write(a, d);
        bus_write(a, d);
        check_irq(req);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NM; k++) begin
            m_data[k] = '0; m_fie[k] = 1'b0; m_eie[k] = 1'b0;
        end
        for (int x = 0; x < NI; x++) m_en[x] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        check("R1 irq", 32'(irq_out), 32'd0);
        check("R12 idle rvalid", 32'(bus_rvalid), 32'd0);
        bus_read(16'h0304, rd); check("R1 status", rd, 32'd0);
        bus_read(mb_addr(5, 12'h000), rd); check("R1 mailbox", rd, 32'd0);
        bus_read(16'h0108, rd); check("R1 enable", rd, 32'd0);

        // R7 dimensioning, R8 ignored writes
        bus_read(16'h0380, rd); check("R7 dim", rd, 32'h0004_0008);
        do_write("R8 dim write", 16'h0380, 32'hFFFF_FFFF);
        bus_read(16'h0380, rd); check("R8 dim unchanged", rd, 32'h0004_0008);

        // R6 enables and R11 per-mailbox enable readback
        do_write("R6 en0", 16'h0100, 32'hABCD_FFFF);
        bus_read(16'h0100, rd); check("R6 en0 readback", rd, 32'h0000_FFFF);
        do_write("R11 eie2", mb_addr(2, 12'h008), 32'hFFFF_FFFF);
        bus_read(mb_addr(2, 12'h008), rd); check("R11 eie readback", rd, 32'd1);
        check("R5 empty irq", 32'(irq_out), 32'b0001);
        bus_read(16'h0304, rd); check("R4 status empty", rd, 32'h0000_0004);

        // R8 write to status ignored
        do_write("R8 status write irq", 16'h0304, 32'hFFFF_FFFF);
        bus_read(16'h0304, rd); check("R8 status unchanged", rd, 32'h0000_0004);

        // R2 / R10 overwrite of full mailbox
        do_write("R11 fie3", mb_addr(3, 12'h004), 32'h1);
        do_write("R2 post", mb_addr(3, 12'h000), 32'h8000_0001);
        do_write("R10 overwrite", mb_addr(3, 12'h000), 32'h8000_0ABC);
        bus_read(mb_addr(3, 12'h000), rd); check("R10 data", rd, 32'h8000_0ABC);
        bus_read(16'h0304, rd); check("R10 still full", rd, 32'(exp_status()));

        // R2 nonzero payload with flag clear counts as empty
        do_write("R2 flag clear", mb_addr(2, 12'h000), 32'h1234_5678);
        bus_read(mb_addr(2, 12'h000), rd); check("R2 payload", rd, 32'h1234_5678);
        bus_read(16'h0304, rd); check("R4 not full", rd, 32'(exp_status()));

        // R3 drain
        do_write("R3 drain", mb_addr(3, 12'h000), 32'h0);
        bus_read(mb_addr(3, 12'h000), rd); check("R3 drained", rd, 32'd0);

        // R9 holes
        bus_read(16'h9000, rd); check("R9 page9", rd, 32'd0);
        bus_read(16'hF304, rd); check("R9 page15", rd, 32'd0);
        bus_read(16'h0200, rd); check("R9 common hole", rd, 32'd0);
        bus_read(16'h0110, rd); check("R9 en beyond", rd, 32'd0);
        bus_read(mb_addr(1, 12'h00C), rd); check("R9 mb hole", rd, 32'd0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom_range(0, 6));
            int k  = int'($urandom_range(0, NM - 1));
            int x  = int'($urandom_range(0, NI - 1));
            logic [31:0] r = $urandom;
            case (op)
                0: do_write("R2 rand post", mb_addr(k, 12'h000), r | 32'h8000_0000);
                1: do_write("R3 rand drain", mb_addr(k, 12'h000), 32'h0);
                2: do_write("R11 rand fie", mb_addr(k, 12'h004), r);
                3: do_write("R11 rand eie", mb_addr(k, 12'h008), r);
                4: do_write("R6 rand mask", 16'(16'h0100 + 4 * x), r);
                5: begin
                    bus_read(mb_addr(k, 12'h000), rd);
                    check("R2 rand readback", rd, m_data[k]);
                end
                default: begin
                    bus_read(16'h0304, rd);
                    check("R4 rand status", rd, 32'(exp_status()));
                end
            endcase
            check_irq("R5 rand level");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule